// File: doc/BRIEF.md
# Address and Data Bus Inversion Encoder

This block sits in a memory controller, just ahead of the pin drivers. For each transfer it decides whether to invert the address group and each data group so that few pins are driven low. The address group is the address bits together with the parity bit. Each data port is split into two equal groups. The block counts the zeros in every group. A group holding more than `N/2 + 1` zeros (integer division, where N is the group size) is sent inverted, and its active-high inversion flag is raised. A flag value of 1 means its group is inverted. One parameter selects between two configurations:

- Wide: 36-bit data, 18-bit data groups, 20 address bits.
- Narrow: 18-bit data, 9-bit data groups, 21 address bits.

Address inversion and data inversion each have their own enable pin. A configuration-cycle input marks register accesses. For these, nothing is inverted, all flags are 0, and only the low byte of port A plus the first port-A flag are driven.

Transfers enter through a valid/ready stream and leave through a one-deep registered valid/ready stage. The input is accepted whenever the stage is empty or the consumer takes the held item in the same cycle, so `in_ready = !out_valid || out_ready`. That means `in_ready` depends combinationally on `out_ready`. While `out_valid` is high and `out_ready` is low, the held item stays unchanged. The enables and `in_cfg` are sampled together with the transfer.

Top module: `bi_encoder`

## Requirements
- R1: With WIDE=1 the address group `{out_par, out_addr[19:0]}` (21 signals) is inverted and `out_ainv`=1 exactly when address inversion is enabled and the input group holds more than 11 zeros.
- R2: With WIDE=0 the 22-signal group `{par, addr[20:0]}` is inverted and flagged exactly when enabled and holding more than 12 zeros.
- R3: With WIDE=1 data group g of a port is bits `[18g+17:18g]`, flagged by bit g of that port's inversion flags. It is inverted exactly when data inversion is enabled and it holds more than 10 zeros.
- R4: With WIDE=0 data group g is bits `[9g+8:9g]`. It is inverted exactly when enabled and holding more than 5 zeros.
- R5: With `addr_inv_en`=0, `out_ainv` is 0 and address/parity pass unchanged. With `data_inv_en`=0, all data flags are 0 and data passes unchanged.
- R6: On a configuration cycle:
  - address and parity pass uninverted, and every flag value is 0;
  - `out_dat_a[7:0]` carries the input low byte with `out_oe_a` = 0xFF in the low byte only;
  - `out_dinv_oe_a` = 01 and `out_dinv_oe_b` = 0;
  - undriven bits read 0.

  On normal cycles every output enable bit is 1.
- R7: An item accepted at a clock edge is presented at the outputs with `out_valid`=1 right after that edge.
- R8: `in_ready` is high whenever the stage is empty. A stalled item is held stable. Items are delivered once each, in order.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.
- R10: XOR-ing each group with its flag recovers the original address, parity and data. With inversion enabled, no transmitted group holds more than its zero limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_inv_en | input | 1 | Enables address inversion |
| data_inv_en | input | 1 | Enables data inversion |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Input item accepted this cycle |
| in_cfg | input | 1 | Item is a configuration-register cycle |
| in_addr | input | AW (20/21) | Address bits |
| in_par | input | 1 | Address parity bit |
| in_dat_a | input | DW (36/18) | Port A write data |
| in_dat_b | input | DW (36/18) | Port B write data |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Consumer takes the output item |
| out_addr | output | AW | Encoded address |
| out_par | output | 1 | Encoded parity |
| out_ainv | output | 1 | Address group inverted |
| out_dat_a | output | DW | Encoded port A data |
| out_dat_b | output | DW | Encoded port B data |
| out_oe_a | output | DW | Drive enables for port A data bits |
| out_oe_b | output | DW | Drive enables for port B data bits |
| out_dinv_a | output | 2 | Port A group inversion flags |
| out_dinv_b | output | 2 | Port B group inversion flags |
| out_dinv_oe_a | output | 2 | Drive enables for port A flags |
| out_dinv_oe_b | output | 2 | Drive enables for port B flags |

## Verification
The assertions assume a synchronous reset and no other input constraint. They assume that the consumer may withhold `out_ready` for any number of cycles. The stall check relies on a held item never changing, whatever the enables or `in_cfg` do while it waits.

The stimulus changes the enables and `in_cfg` only together with a new item, at the falling edge. It changes `out_ready` only just after a rising edge. This keeps every sampled value unambiguous.

Data patterns are swept across each group's exact threshold, and random, biased and configuration items are mixed under random back-pressure.

// File: rtl/bi_pkg.sv
package bi_pkg;
  localparam int REG_BYTE_W = 8;
  localparam int NUM_GROUPS = 2;

  function automatic int addr_bits(input bit wide);
    return wide ? 20 : 21;
  endfunction

  function automatic int data_bits(input bit wide);
    return wide ? 36 : 18;
  endfunction

  function automatic int group_bits(input bit wide);
    return data_bits(wide) / NUM_GROUPS;
  endfunction

  // largest zero count a group may carry without being inverted
  function automatic int zero_limit(input int n);
    return n / 2 + 1;
  endfunction
endpackage

// File: rtl/bi_zero_count.sv
module bi_zero_count #(
  parameter int W = 18
) (
  input  logic [W-1:0]           bits,
  output logic [$clog2(W+1)-1:0] zeros
);
  localparam int CW = $clog2(W + 1);

  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++) begin
      zeros = zeros + CW'(!bits[i]);
    end
  end
endmodule

// File: rtl/bi_group_enc.sv
module bi_group_enc #(
  parameter int W = 18
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic         inv
);
  localparam int CW    = $clog2(W + 1);
  localparam int LIMIT = bi_pkg::zero_limit(W);

  logic [CW-1:0] zeros;

  bi_zero_count #(.W(W)) u_cnt (
    .bits  (din),
    .zeros (zeros)
  );

  assign inv  = en && (zeros > CW'(LIMIT));
  assign dout = inv ? ~din : din;
endmodule

// File: rtl/bi_encoder.sv
module bi_encoder import bi_pkg::*; #(
  parameter bit WIDE = 1'b1,
  localparam int AW = addr_bits(WIDE),
  localparam int DW = data_bits(WIDE),
  localparam int NG = NUM_GROUPS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_inv_en,
  input  logic          data_inv_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_cfg,
  input  logic [AW-1:0] in_addr,
  input  logic          in_par,
  input  logic [DW-1:0] in_dat_a,
  input  logic [DW-1:0] in_dat_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_par,
  output logic          out_ainv,
  output logic [DW-1:0] out_dat_a,
  output logic [DW-1:0] out_dat_b,
  output logic [DW-1:0] out_oe_a,
  output logic [DW-1:0] out_oe_b,
  output logic [NG-1:0] out_dinv_a,
  output logic [NG-1:0] out_dinv_b,
  output logic [NG-1:0] out_dinv_oe_a,
  output logic [NG-1:0] out_dinv_oe_b
);
  localparam int GW = group_bits(WIDE);

  logic          a_en, d_en, a_inv;
  logic [AW:0]   a_grp;
  logic [DW-1:0] enc_a, enc_b;
  logic [NG-1:0] inv_a, inv_b;

  // next-state values for the output stage
  logic [AW-1:0] nx_addr;
  logic          nx_par, nx_ainv;
  logic [DW-1:0] nx_a, nx_b, nx_oe_a, nx_oe_b;
  logic [NG-1:0] nx_ia, nx_ib, nx_ioa, nx_iob;

  // register accesses never invert
  assign a_en = addr_inv_en && !in_cfg;
  assign d_en = data_inv_en && !in_cfg;

  bi_group_enc #(.W(AW + 1)) u_addr_enc (
    .din  ({in_par, in_addr}),
    .en   (a_en),
    .dout (a_grp),
    .inv  (a_inv)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    bi_group_enc #(.W(GW)) u_enc_a (
      .din  (in_dat_a[g*GW +: GW]),
      .en   (d_en),
      .dout (enc_a[g*GW +: GW]),
      .inv  (inv_a[g])
    );
    bi_group_enc #(.W(GW)) u_enc_b (
      .din  (in_dat_b[g*GW +: GW]),
      .en   (d_en),
      .dout (enc_b[g*GW +: GW]),
      .inv  (inv_b[g])
    );
  end

  always_comb begin
    if (in_cfg) begin
      nx_addr = in_addr;
      nx_par  = in_par;
      nx_ainv = 1'b0;
      nx_a    = '0;
      nx_a[REG_BYTE_W-1:0]    = in_dat_a[REG_BYTE_W-1:0];
      nx_oe_a = '0;
      nx_oe_a[REG_BYTE_W-1:0] = '1;
      nx_b    = '0;
      nx_oe_b = '0;
      nx_ia   = '0;
      nx_ib   = '0;
      nx_ioa  = '0;
      nx_ioa[0] = 1'b1;
      nx_iob  = '0;
    end else begin
      nx_addr = a_grp[AW-1:0];
      nx_par  = a_grp[AW];
      nx_ainv = a_inv;
      nx_a    = enc_a;
      nx_oe_a = '1;
      nx_b    = enc_b;
      nx_oe_b = '1;
      nx_ia   = inv_a;
      nx_ib   = inv_b;
      nx_ioa  = '1;
      nx_iob  = '1;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_addr      <= nx_addr;
      out_par       <= nx_par;
      out_ainv      <= nx_ainv;
      out_dat_a     <= nx_a;
      out_dat_b     <= nx_b;
      out_oe_a      <= nx_oe_a;
      out_oe_b      <= nx_oe_b;
      out_dinv_a    <= nx_ia;
      out_dinv_b    <= nx_ib;
      out_dinv_oe_a <= nx_ioa;
      out_dinv_oe_b <= nx_iob;
    end
  end
endmodule

// File: rtl/bi_encoder_chk.sv
module bi_encoder_chk import bi_pkg::*; #(
  parameter bit WIDE = 1'b1,
  localparam int AW = addr_bits(WIDE),
  localparam int DW = data_bits(WIDE),
  localparam int NG = NUM_GROUPS
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_par,
  input logic          out_ainv,
  input logic [DW-1:0] out_dat_a,
  input logic [DW-1:0] out_dat_b,
  input logic [DW-1:0] out_oe_a,
  input logic [DW-1:0] out_oe_b,
  input logic [NG-1:0] out_dinv_a,
  input logic [NG-1:0] out_dinv_b
);
  localparam int GW   = group_bits(WIDE);
  localparam int ALIM = zero_limit(AW + 1);
  localparam int DLIM = zero_limit(GW);
  localparam logic [DW-1:0] REG_MASK = {{(DW-REG_BYTE_W){1'b0}}, {REG_BYTE_W{1'b1}}};

  // R7: an accepted item shows up right after the edge
  a_r7_fill: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R8: an empty stage always accepts
  a_r8_empty_ready: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R8: a stalled item is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_par)
      && $stable(out_dat_a) && $stable(out_dat_b) && $stable(out_dinv_a)
      && $stable(out_dinv_b) && $stable(out_ainv));

  // R6: a register cycle drives only the low port-A byte and carries no flags
  a_r6_cfg: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_oe_b == '0) |-> !out_ainv && (out_dinv_a == '0)
      && (out_dinv_b == '0) && (out_oe_a == REG_MASK));

  // R10: an inverted address group respects the zero limit
  a_r10_addr_limit: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ainv |-> $countones(~{out_par, out_addr}) <= ALIM);

  for (genvar g = 0; g < NG; g++) begin : g_lim
    // R10: an inverted data group respects the zero limit
    a_r10_data_limit: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_dinv_a[g] || out_dinv_b[g]) |->
        (!out_dinv_a[g] || $countones(~out_dat_a[g*GW +: GW]) <= DLIM)
        && (!out_dinv_b[g] || $countones(~out_dat_b[g*GW +: GW]) <= DLIM));
  end
endmodule

bind bi_encoder bi_encoder_chk #(.WIDE(WIDE)) u_chk (.*);

// File: tb/bi_encoder_tb.sv
`timescale 1ns/1ps

module bi_decoder #(
  parameter int AW = 20,
  parameter int GW = 18
) (
  input  logic [AW-1:0]     addr,
  input  logic              par,
  input  logic              ainv,
  input  logic [2*GW-1:0]   dq_a,
  input  logic [2*GW-1:0]   dq_b,
  input  logic [1:0]        inv_a,
  input  logic [1:0]        inv_b,
  output logic [AW-1:0]     dec_addr,
  output logic              dec_par,
  output logic [2*GW-1:0]   dec_a,
  output logic [2*GW-1:0]   dec_b
);
  assign dec_addr = addr ^ {AW{ainv}};
  assign dec_par  = par ^ ainv;
  for (genvar g = 0; g < 2; g++) begin : g_dec
    assign dec_a[g*GW +: GW] = dq_a[g*GW +: GW] ^ {GW{inv_a[g]}};
    assign dec_b[g*GW +: GW] = dq_b[g*GW +: GW] ^ {GW{inv_b[g]}};
  end
endmodule

module bi_encoder_tb;
  typedef struct {
    logic [20:0] addr;
    logic        par, ainv;
    logic [35:0] da, db, oea, oeb;
    logic [1:0]  ia, ib, ioa, iob;
    logic [20:0] o_addr;
    logic        o_par;
    logic [35:0] o_da, o_db;
    logic        cfg, ae, de;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        aen, den, s_valid, s_cfg, s_par, out_rdy, bp_on;
  logic [20:0] s_addr;
  logic [35:0] s_da, s_db;

  logic        w_in_ready, w_valid, w_par, w_ainv;
  logic [19:0] w_addr;
  logic [35:0] w_da, w_db, w_oea, w_oeb;
  logic [1:0]  w_ia, w_ib, w_ioa, w_iob;
  logic        n_in_ready, n_valid, n_par, n_ainv;
  logic [20:0] n_addr;
  logic [17:0] n_da, n_db, n_oea, n_oeb;
  logic [1:0]  n_ia, n_ib, n_ioa, n_iob;

  logic [19:0] wd_addr;
  logic        wd_par;
  logic [35:0] wd_a, wd_b;
  logic [20:0] nd_addr;
  logic        nd_par;
  logic [17:0] nd_a, nd_b;

  int n_checks = 0;
  int n_fail = 0;
  item_t qw[$];
  item_t qn[$];

  bi_encoder #(.WIDE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .addr_inv_en(aen), .data_inv_en(den),
    .in_valid(s_valid), .in_ready(w_in_ready), .in_cfg(s_cfg),
    .in_addr(s_addr[19:0]), .in_par(s_par), .in_dat_a(s_da), .in_dat_b(s_db),
    .out_valid(w_valid), .out_ready(out_rdy), .out_addr(w_addr), .out_par(w_par),
    .out_ainv(w_ainv), .out_dat_a(w_da), .out_dat_b(w_db), .out_oe_a(w_oea),
    .out_oe_b(w_oeb), .out_dinv_a(w_ia), .out_dinv_b(w_ib),
    .out_dinv_oe_a(w_ioa), .out_dinv_oe_b(w_iob));

  bi_encoder #(.WIDE(1'b0)) u_dut_n (
    .clk(clk), .rst(rst), .addr_inv_en(aen), .data_inv_en(den),
    .in_valid(s_valid), .in_ready(n_in_ready), .in_cfg(s_cfg),
    .in_addr(s_addr), .in_par(s_par), .in_dat_a(s_da[17:0]), .in_dat_b(s_db[17:0]),
    .out_valid(n_valid), .out_ready(out_rdy), .out_addr(n_addr), .out_par(n_par),
    .out_ainv(n_ainv), .out_dat_a(n_da), .out_dat_b(n_db), .out_oe_a(n_oea),
    .out_oe_b(n_oeb), .out_dinv_a(n_ia), .out_dinv_b(n_ib),
    .out_dinv_oe_a(n_ioa), .out_dinv_oe_b(n_iob));

  bi_decoder #(.AW(20), .GW(18)) u_dec_w (
    .addr(w_addr), .par(w_par), .ainv(w_ainv), .dq_a(w_da), .dq_b(w_db),
    .inv_a(w_ia), .inv_b(w_ib), .dec_addr(wd_addr), .dec_par(wd_par),
    .dec_a(wd_a), .dec_b(wd_b));

  bi_decoder #(.AW(21), .GW(9)) u_dec_n (
    .addr(n_addr), .par(n_par), .ainv(n_ainv), .dq_a(n_da), .dq_b(n_db),
    .inv_a(n_ia), .inv_b(n_ib), .dec_addr(nd_addr), .dec_par(nd_par),
    .dec_a(nd_a), .dec_b(nd_b));

  function automatic int zc(logic [35:0] v, int lo, int n);
    int z = 0;
    for (int i = 0; i < n; i++) z += (v[lo + i] == 1'b0) ? 1 : 0;
    return z;
  endfunction

  // expected encoder output, built from the requirements
  function automatic item_t model(int aw, int gw, logic [20:0] a, logic p,
                                  logic [35:0] da, logic [35:0] db,
                                  logic cfg, logic ae, logic de);
    item_t it;
    int z;
    logic inv;
    it = '{default: '0};
    for (int i = 0; i < aw; i++) it.o_addr[i] = a[i];
    for (int i = 0; i < 2 * gw; i++) begin
      it.o_da[i] = da[i];
      it.o_db[i] = db[i];
    end
    it.o_par = p;
    it.cfg = cfg; it.ae = ae; it.de = de;
    if (cfg) begin
      it.addr = it.o_addr;
      it.par = p;
      it.da[7:0] = da[7:0];
      it.oea[7:0] = 8'hFF;
      it.ioa = 2'b01;
    end else begin
      z = zc({15'h0, a}, 0, aw) + (p ? 0 : 1);
      inv = ae && (z > (aw + 1) / 2 + 1);
      it.ainv = inv;
      for (int i = 0; i < aw; i++) it.addr[i] = a[i] ^ inv;
      it.par = p ^ inv;
      for (int g = 0; g < 2; g++) begin
        it.ia[g] = de && (zc(da, g * gw, gw) > gw / 2 + 1);
        it.ib[g] = de && (zc(db, g * gw, gw) > gw / 2 + 1);
        for (int i = 0; i < gw; i++) begin
          it.da[g*gw + i] = da[g*gw + i] ^ it.ia[g];
          it.db[g*gw + i] = db[g*gw + i] ^ it.ib[g];
        end
      end
      for (int i = 0; i < 2 * gw; i++) begin
        it.oea[i] = 1'b1;
        it.oeb[i] = 1'b1;
      end
      it.ioa = 2'b11;
      it.iob = 2'b11;
    end
    return it;
  endfunction

  task automatic check(string tag, string what, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic verify(bit wide, item_t e, int aw, int gw,
                        logic [20:0] a_addr, logic a_par, logic a_ainv,
                        logic [35:0] a_da, logic [35:0] a_db,
                        logic [35:0] a_oea, logic [35:0] a_oeb,
                        logic [1:0] a_ia, logic [1:0] a_ib,
                        logic [1:0] a_ioa, logic [1:0] a_iob,
                        logic [20:0] d_addr, logic d_par,
                        logic [35:0] d_da, logic [35:0] d_db);
    string ta, td;
    int z;
    ta = e.cfg ? "R6" : (!e.ae ? "R5" : (wide ? "R1" : "R2"));
    td = e.cfg ? "R6" : (!e.de ? "R5" : (wide ? "R3" : "R4"));
    check(ta, "address", {15'h0, a_addr}, {15'h0, e.addr});
    check(ta, "parity/ainv", {34'h0, a_par, a_ainv}, {34'h0, e.par, e.ainv});
    check(td, "port A data", a_da, e.da);
    check(td, "port B data", a_db, e.db);
    check(td, "data flags", {32'h0, a_ia, a_ib}, {32'h0, e.ia, e.ib});
    check("R6", "port A drive", a_oea, e.oea);
    check("R6", "port B drive", a_oeb, e.oeb);
    check("R6", "flag drive", {32'h0, a_ioa, a_iob}, {32'h0, e.ioa, e.iob});
    if (!e.cfg) begin
      check("R10", "decoded address", {14'h0, d_par, d_addr}, {14'h0, e.o_par, e.o_addr});
      check("R10", "decoded port A", d_da, e.o_da);
      check("R10", "decoded port B", d_db, e.o_db);
      if (e.ae) begin
        z = zc({15'h0, a_addr}, 0, aw) + (a_par ? 0 : 1);
        check("R10", "address zero limit", {35'h0, z > (aw + 1) / 2 + 1}, 36'h0);
      end
      if (e.de) begin
        for (int g = 0; g < 2; g++) begin
          check("R10", "port A zero limit", {35'h0, zc(a_da, g * gw, gw) > gw / 2 + 1}, 36'h0);
          check("R10", "port B zero limit", {35'h0, zc(a_db, g * gw, gw) > gw / 2 + 1}, 36'h0);
        end
      end
    end
  endtask

  // monitors: pop and compare when the consumer takes an item
  always @(negedge clk) begin
    if (!rst && w_valid && out_rdy) begin
      if (qw.size() == 0) begin
        check("R8", "wide output with no item sent", 36'h1, 36'h0);
      end else begin
        item_t e;
        e = qw.pop_front();
        verify(1'b1, e, 20, 18, {1'b0, w_addr}, w_par, w_ainv, w_da, w_db,
               w_oea, w_oeb, w_ia, w_ib, w_ioa, w_iob,
               {1'b0, wd_addr}, wd_par, wd_a, wd_b);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && n_valid && out_rdy) begin
      if (qn.size() == 0) begin
        check("R8", "narrow output with no item sent", 36'h1, 36'h0);
      end else begin
        item_t e;
        e = qn.pop_front();
        verify(1'b0, e, 21, 9, n_addr, n_par, n_ainv, {18'h0, n_da}, {18'h0, n_db},
               {18'h0, n_oea}, {18'h0, n_oeb}, n_ia, n_ib, n_ioa, n_iob,
               nd_addr, nd_par, {18'h0, nd_a}, {18'h0, nd_b});
      end
    end
  end

  // consumer back-pressure, changed just after each rising edge
  initial begin
    out_rdy = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      out_rdy = bp_on ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // driver: called at a falling edge, returns at a falling edge
  task automatic send(logic [20:0] a, logic p, logic [35:0] da, logic [35:0] db,
                      logic cfg, logic ae, logic de);
    bit done = 0;
    bit rdy;
    s_addr = a; s_par = p; s_da = da; s_db = db; s_cfg = cfg;
    aen = ae; den = de; s_valid = 1'b1;
    while (!done) begin
      rdy = w_in_ready;
      @(posedge clk);
      if (rdy) begin
        done = 1;
        qw.push_back(model(20, 18, a, p, da, db, cfg, ae, de));
        qn.push_back(model(21, 9, a, p, da, db, cfg, ae, de));
      end
      @(negedge clk);
    end
    check("R7", "wide valid after accept", {35'h0, w_valid}, 36'h1);
    check("R7", "narrow valid after accept", {35'h0, n_valid}, 36'h1);
    check("R8", "ready match", {35'h0, n_in_ready}, {35'h0, w_in_ready});
  endtask

  function automatic logic [35:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  initial begin
    s_valid = 0; s_cfg = 0; s_par = 0; s_addr = '0; s_da = '0; s_db = '0;
    aen = 1; den = 1; bp_on = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "wide valid after reset", {35'h0, w_valid}, 36'h0);
    check("R9", "narrow valid after reset", {35'h0, n_valid}, 36'h0);
    check("R9", "ready after reset", {34'h0, w_in_ready, n_in_ready}, 36'h3);

    // threshold sweep: k zeros in address group and in data group 0 / group 1
    for (int k = 3; k <= 14; k++) begin
      send(21'h1FFFFF << k, 1'b1, 36'hF_FFFF_FFFF << k,
           ~(((36'h1 << k) - 36'h1) << 18), 1'b0, 1'b1, 1'b1);
    end
    for (int k = 3; k <= 14; k++) begin
      send(21'h1FFFFF << k, 1'b0, ~(((36'h1 << k) - 36'h1) << 9),
           ~(((36'h1 << k) - 36'h1) << 27), 1'b0, 1'b1, 1'b1);
    end
    send(21'h0, 1'b0, 36'h0, 36'h0, 1'b0, 1'b1, 1'b1);
    send(21'h1FFFFF, 1'b1, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 1'b1);
    send(21'h0, 1'b0, 36'h0, 36'h0, 1'b0, 1'b0, 1'b0);
    send(21'h0, 1'b0, 36'h0, 36'h0, 1'b1, 1'b1, 1'b1);
    send(21'h0, 1'b0, 36'hA5, 36'h0, 1'b1, 1'b1, 1'b1);

    // random traffic with back-pressure
    bp_on = 1;
    for (int n = 0; n < 300; n++) begin
      logic [35:0] ra, rb;
      ra = rnd36(); rb = rnd36();
      if (n % 2 == 1) begin
        ra = ra & rnd36();
        rb = rb & rnd36();
      end
      send($urandom, $urandom, ra, rb, 1'b0, 1'b1, 1'b1);
    end
    // enables off
    for (int n = 0; n < 40; n++) begin
      send($urandom & $urandom, $urandom, rnd36() & rnd36(), rnd36() & rnd36(),
           1'b0, n[0], n[1]);
    end
    // mixed with configuration cycles
    for (int n = 0; n < 200; n++) begin
      send($urandom & $urandom, $urandom, rnd36() & rnd36(), rnd36() & rnd36(),
           ($urandom % 4) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
    end

    s_valid = 1'b0;
    bp_on = 0;
    repeat (8) @(negedge clk);
    check("R8", "wide items left undelivered", 36'(qw.size()), 36'h0);
    check("R8", "narrow items left undelivered", 36'(qn.size()), 36'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule